// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block holds the instruction fetch address of a small controller with a 1K-word program memory. Each cycle one update code selects where the next address comes from. The address can stay where it is or step forward by one. It can be rebuilt from a data byte plus a stored upper part, or loaded whole from a jump target. It can be popped from an eight-entry return stack. It can also be forced to the interrupt vector.

Software changes the two upper address bits in two steps. First it writes them into a small holding register. They take effect only when the low byte is written later. Calls and interrupt entries save the address that follows the current one on a circular return stack. A depth count with empty and full flags reports how many saved addresses are valid.

Top module: `pc_sequencer`

## Requirements
- R1: A synchronous active-low reset sets the fetch address to 0, the holding register readback to 0, the stack depth to 0, the empty flag to 1 and the full flag to 0.
- R2: With op code 0 (hold) or the unused code 7, the fetch address does not change.
- R3: With op code 1 (step), the fetch address becomes the old address plus one, modulo 1024, so 0x3FF is followed by 0x000.
- R4: With op code 3 (jump), the fetch address becomes the 10-bit target input and the stack is untouched.
- R5: With op code 2 (low write), address bits 7:0 take the data byte and bits 9:8 take the holding register. If the holding register is written in the same cycle, its value from before that write is used.
- R6: With op code 4 (call), the old address plus one (modulo 1024) is pushed and the fetch address becomes the target. With op code 5 (return, used for every return kind), the fetch address becomes the most recently pushed value still on the stack, and that value is removed.
- R7: With op code 6 (interrupt entry), the old address plus one is pushed and the fetch address becomes 0x004.
- R8: A holding register write stores data bits 1:0 only. The readback byte shows them in bits 1:0 with bits 7:2 at zero. A write alone leaves the fetch address unchanged.
- R9: The depth output counts pushes minus pops, limited to 0..8. The empty flag is 1 exactly at depth 0 and the full flag is 1 exactly at depth 8.
- R10: The stack is circular over 8 slots. A ninth push overwrites the oldest entry. Pops past the valid entries keep cycling through the slots, most recent first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 3 | Update code (0 hold, 1 step, 2 low write, 3 jump, 4 call, 5 return, 6 interrupt entry) |
| wr_data_i | input | 8 | Data byte for a low write |
| target_i | input | 10 | Jump or call target from the instruction word |
| lat_we_i | input | 1 | Holding register write enable |
| lat_wdata_i | input | 8 | Holding register write data |
| pc_o | output | 10 | Current fetch address |
| lat_rdata_o | output | 8 | Holding register readback |
| stk_depth_o | output | 4 | Number of valid saved addresses |
| stk_empty_o | output | 1 | Stack holds no valid address |
| stk_full_o | output | 1 | Stack holds eight valid addresses |

## Verification
A wrong stack pointer or a corrupted slot stays hidden until the next return. The bench therefore nests calls and interrupt entries up to and past eight levels, then unwinds them all and compares every returned address one cycle after the pop. A depth count that drifts shows on the depth and flag outputs in the cycle after the faulty push or pop. A wrong source selection shows on the fetch address one cycle after the update code. The bench sweeps all 1024 jump targets, a full wrap of the step path, and every holding value combined with several low bytes.

// File: rtl/pc_seq_pkg.sv
// Shared update codes for the program counter sequencer.
// Assumes one update code per cycle; codes not listed act as hold.
package pc_seq_pkg;
    typedef enum logic [2:0] {
        PC_HOLD = 3'd0,
        PC_STEP = 3'd1,
        PC_WRLO = 3'd2,
        PC_JUMP = 3'd3,
        PC_CALL = 3'd4,
        PC_RET  = 3'd5,
        PC_IRQ  = 3'd6
    } pc_op_e;
endpackage

// File: rtl/pc_hi_latch.sv
// Holding register for the upper fetch address bits.
// Stores only HI_W bits. The readback pads the rest of the byte with zeros.
// Assumes a write takes effect at the next clock edge.
module pc_hi_latch #(
    parameter int LO_W = 8,
    parameter int HI_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_i,
    input  logic [LO_W-1:0] wdata_i,
    output logic [HI_W-1:0] hi_o,
    output logic [LO_W-1:0] rdata_o
);
    logic [HI_W-1:0] hi_q;
    logic            unused_pad;

    // Capture the meaningful bits on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)    hi_q <= '0;
        else if (we_i) hi_q <= wdata_i[HI_W-1:0];
    end

    assign unused_pad = ^wdata_i[LO_W-1:HI_W];
    assign hi_o       = hi_q;
    assign rdata_o    = {{(LO_W-HI_W){1'b0}}, hi_q};

    AST_LAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(hi_o)); // R8
endmodule

// File: rtl/pc_ret_stack.sv
// Circular return stack with a saturating depth count.
// The pointer marks the next free slot and wraps over DEPTH slots, so an
// overflowing push replaces the oldest entry. Assumes DEPTH is a power of two
// and that push and pop never occur together.
module pc_ret_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_i,
    input  logic                       pop_i,
    input  logic [W-1:0]               push_val_i,
    output logic [W-1:0]               top_o,
    output logic [$clog2(DEPTH+1)-1:0] depth_o,
    output logic                       empty_o,
    output logic                       full_o
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    logic [W-1:0]     slot_q [DEPTH];
    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_dec;
    logic [CNT_W-1:0] cnt_q;

    assign ptr_dec = ptr_q - 1'b1;
    assign top_o   = slot_q[ptr_dec];

    // Write the pushed value into the free slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else if (push_i) begin
            slot_q[ptr_q] <= push_val_i;
        end
    end

    // Move the wrapping pointer on push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr_q <= '0;
        else if (push_i) ptr_q <= ptr_q + 1'b1;
        else if (pop_i)  ptr_q <= ptr_dec;
    end

    // Track the number of valid entries, limited to 0..DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n)                           cnt_q <= '0;
        else if (push_i && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
        else if (pop_i && cnt_q != '0)        cnt_q <= cnt_q - 1'b1;
    end

    assign depth_o = cnt_q;
    assign empty_o = (cnt_q == '0);
    assign full_o  = (cnt_q == CNT_MAX);

    AST_NO_PUSH_POP: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && pop_i)); // R6
    AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        depth_o <= CNT_MAX); // R9
    AST_PUSH_SAVED: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> top_o == $past(push_val_i)); // R10
endmodule

// File: rtl/pc_next_sel.sv
// Combinational source selection for the next fetch address.
// It also issues the stack push and pop requests. Codes without a meaning
// here hold the address.
module pc_next_sel
    import pc_seq_pkg::*;
#(
    parameter int PC_W    = 10,
    parameter int LO_W    = 8,
    parameter int IRQ_VEC = 4
) (
    input  logic [2:0]         op_i,
    input  logic [PC_W-1:0]    pc_i,
    input  logic [LO_W-1:0]    wr_data_i,
    input  logic [PC_W-LO_W-1:0] hi_i,
    input  logic [PC_W-1:0]    target_i,
    input  logic [PC_W-1:0]    top_i,
    output logic [PC_W-1:0]    next_o,
    output logic [PC_W-1:0]    push_val_o,
    output logic               push_o,
    output logic               pop_o
);
    pc_op_e op;
    assign op         = pc_op_e'(op_i);
    assign push_val_o = pc_i + 1'b1;

    // Choose the address source and the stack action.
    always_comb begin
        next_o = pc_i;
        push_o = 1'b0;
        pop_o  = 1'b0;
        unique case (op)
            PC_STEP: next_o = pc_i + 1'b1;
            PC_WRLO: next_o = {hi_i, wr_data_i};
            PC_JUMP: next_o = target_i;
            PC_CALL: begin next_o = target_i; push_o = 1'b1; end
            PC_RET:  begin next_o = top_i;    pop_o  = 1'b1; end
            PC_IRQ:  begin next_o = PC_W'(IRQ_VEC); push_o = 1'b1; end
            default: next_o = pc_i;
        endcase
    end
endmodule

// File: rtl/pc_sequencer.sv
// Program counter sequencer: the fetch address register, the holding
// register for the upper bits, and the return stack.
// Assumes one update code per cycle and an instruction memory of 2**PC_W words.
module pc_sequencer
    import pc_seq_pkg::*;
#(
    parameter int PC_W    = 10,
    parameter int LO_W    = 8,
    parameter int DEPTH   = 8,
    parameter int IRQ_VEC = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [2:0]                 op_i,
    input  logic [LO_W-1:0]            wr_data_i,
    input  logic [PC_W-1:0]            target_i,
    input  logic                       lat_we_i,
    input  logic [LO_W-1:0]            lat_wdata_i,
    output logic [PC_W-1:0]            pc_o,
    output logic [LO_W-1:0]            lat_rdata_o,
    output logic [$clog2(DEPTH+1)-1:0] stk_depth_o,
    output logic                       stk_empty_o,
    output logic                       stk_full_o
);
    localparam int HI_W = PC_W - LO_W;

    logic [PC_W-1:0] pc_q, pc_next, push_val, top;
    logic [HI_W-1:0] hi;
    logic            push, pop;

    pc_hi_latch #(.LO_W(LO_W), .HI_W(HI_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .we_i(lat_we_i), .wdata_i(lat_wdata_i),
        .hi_o(hi), .rdata_o(lat_rdata_o)
    );

    pc_next_sel #(.PC_W(PC_W), .LO_W(LO_W), .IRQ_VEC(IRQ_VEC)) u_sel (
        .op_i(op_i), .pc_i(pc_q), .wr_data_i(wr_data_i), .hi_i(hi),
        .target_i(target_i), .top_i(top), .next_o(pc_next),
        .push_val_o(push_val), .push_o(push), .pop_o(pop)
    );

    pc_ret_stack #(.DEPTH(DEPTH), .W(PC_W)) u_stack (
        .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop),
        .push_val_i(push_val), .top_o(top), .depth_o(stk_depth_o),
        .empty_o(stk_empty_o), .full_o(stk_full_o)
    );

    // Register the selected next fetch address.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_next;
    end

    assign pc_o = pc_q;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == PC_HOLD) |=> $stable(pc_o)); // R2
    AST_STEP_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == PC_STEP) |=> pc_o == PC_W'($past(pc_o) + 1'b1)); // R3
    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == PC_JUMP) |=> pc_o == $past(target_i)); // R4
    AST_WRLO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == PC_WRLO) |=> pc_o[LO_W-1:0] == $past(wr_data_i)); // R5
    AST_RET_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == PC_RET) |=> pc_o == $past(top)); // R6
    AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == PC_IRQ) |=> pc_o == PC_W'(IRQ_VEC)); // R7
endmodule

// File: tb/pc_sequencer_tb_top.sv
// Self-checking bench with an arithmetic reference model.
module pc_sequencer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [9:0] target = 10'd0;
    logic       lat_we = 1'b0;
    logic [7:0] lat_wdata = 8'd0;
    logic [9:0] pc;
    logic [7:0] lat_rdata;
    logic [3:0] depth;
    logic       empty, full;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    int m_pc = 0, m_lat = 0, m_ptr = 0, m_depth = 0;
    int m_mem [8];

    always #5 clk = ~clk;

    pc_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .op_i(op), .wr_data_i(wr_data),
        .target_i(target), .lat_we_i(lat_we), .lat_wdata_i(lat_wdata),
        .pc_o(pc), .lat_rdata_o(lat_rdata), .stk_depth_o(depth),
        .stk_empty_o(empty), .stk_full_o(full)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, int'(pc), m_pc);
        chk("R9 depth", int'(depth), m_depth);
        chk("R9 empty", int'(empty), int'(m_depth == 0));
        chk("R9 full", int'(full), int'(m_depth == 8));
        chk("R8 readback", int'(lat_rdata), m_lat);
    endtask

    task automatic m_push(input int v);
        m_mem[m_ptr] = v % 1024;
        m_ptr = (m_ptr + 1) % 8;
        if (m_depth < 8) m_depth++;
    endtask

    // Apply one update, advance the model, and compare after the edge.
    task automatic step(input int o, input int d, input int t, input bit lwe,
                        input int ld, input string tag);
        @(negedge clk);
        op = 3'(o); wr_data = 8'(d); target = 10'(t);
        lat_we = lwe; lat_wdata = 8'(ld);
        @(posedge clk);
        case (o)
            1: m_pc = (m_pc + 1) % 1024;
            2: m_pc = m_lat * 256 + d;
            3: m_pc = t;
            4: begin m_push(m_pc + 1); m_pc = t; end
            5: begin
                m_ptr = (m_ptr + 7) % 8;
                m_pc = m_mem[m_ptr];
                if (m_depth > 0) m_depth--;
            end
            6: begin m_push(m_pc + 1); m_pc = 4; end
            default: ;
        endcase
        if (lwe) m_lat = ld % 4;
        #1;
        check_all(tag);
        @(negedge clk);
        op = 3'd0; lat_we = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) m_mem[i] = 0;
        repeat (3) @(posedge clk);
        #1;
        check_all("R1 reset");
        @(negedge clk);
        rst_n = 1'b1;

        // Hold and the unused code keep the address.
        step(3, 0, 10'h155, 1'b0, 0, "R4 jump");
        step(0, 0, 0, 1'b0, 0, "R2 hold");
        step(7, 0, 0, 1'b0, 0, "R2 code7");

        // Step across the full address range and the wrap.
        step(3, 0, 10'h3F0, 1'b0, 0, "R4 jump");
        for (int i = 0; i < 1040; i++) step(1, 0, 0, 1'b0, 0, "R3 step");

        // Every jump target.
        for (int t = 0; t < 1024; t++) step(3, 0, t, 1'b0, 0, "R4 jump sweep");

        // Holding values times low bytes, write alone leaves the address.
        for (int h = 0; h < 4; h++) begin
            step(0, 0, 0, 1'b1, 8'hFC | h, "R8 latch write");
            for (int b = 0; b < 256; b += 17)
                step(2, b, 0, 1'b0, 0, "R5 low write");
        end
        // Same-cycle latch write uses the old value.
        step(0, 0, 0, 1'b1, 1, "R8 latch write");
        step(2, 8'hAA, 0, 1'b1, 3, "R5 old latch");
        step(2, 8'h55, 0, 1'b0, 0, "R5 new latch");

        // Nested calls, then unwind.
        step(3, 0, 10'h100, 1'b0, 0, "R4 jump");
        for (int k = 0; k < 5; k++) step(4, 0, 10'h200 + 16 * k, 1'b0, 0, "R6 call");
        step(6, 0, 0, 1'b0, 0, "R7 irq entry");
        for (int k = 0; k < 6; k++) step(5, 0, 0, 1'b0, 0, "R6 return");

        // Call from the top address wraps the saved value to 0.
        step(3, 0, 10'h3FF, 1'b0, 0, "R4 jump");
        step(4, 0, 10'h080, 1'b0, 0, "R6 call top");
        step(5, 0, 0, 1'b0, 0, "R6 return wrap");

        // Overflow: ten pushes then twelve pops.
        for (int k = 0; k < 10; k++) step(4, 0, 10'h040 + k * 3, 1'b0, 0, "R10 overflow push");
        for (int k = 0; k < 12; k++) step(5, 0, 0, 1'b0, 0, "R10 circular pop");

        // Interrupt entry at full depth and from an empty stack.
        for (int k = 0; k < 9; k++) step(6, 0, 0, 1'b0, 0, "R7 irq repeat");
        for (int k = 0; k < 9; k++) step(5, 0, 0, 1'b0, 0, "R10 pop");

        // Reset in mid-flight.
        step(4, 0, 10'h123, 1'b1, 2, "R6 call");
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        m_pc = 0; m_lat = 0; m_ptr = 0; m_depth = 0;
        for (int i = 0; i < 8; i++) m_mem[i] = 0;
        #1;
        check_all("R1 reset again");
        @(negedge clk);
        rst_n = 1'b1;
        step(5, 0, 0, 1'b0, 0, "R10 pop after reset");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule